// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a synchronous host read and write an external asynchronous static RAM. The RAM holds 262,144 words of 16 bits, is selected by an 18-bit address, and has a lower byte lane (bits 7:0) and an upper byte lane (bits 15:8). The host issues one word request at a time on a valid/ready port, giving the address, a write flag, write data and two byte enables. The controller then plays out a fixed strobe sequence on the memory pins. A read returns its data with a one-cycle response pulse.

Every strobe interval is derived from nanosecond timing parameters and the clock period. Each interval is rounded up to whole cycles, and every nonzero interval gets at least one cycle. A speed-grade parameter picks the 85 ns set (GRADE=0, the default) or the 100 ns set (GRADE=1). The bidirectional data bus appears as separate data-out, data-in and drive-enable signals, and the pad ring combines them.

The machine has six states:
- IDLE: parked, ready high.
- WGAP: write enable low with the drivers off, which gives the bus its turnaround.
- WDRV: write enable low with the drivers on, which provides data setup.
- WREC: write enable high with the drivers held on, which provides data hold and cycle padding.
- RACC: output enable low, the access window.
- RREC: all strobes high, the bus release time.

Its transitions are:
- IDLE→WGAP on an accepted write.
- IDLE→RACC on an accepted read.
- WGAP→WDRV, WDRV→WREC, WREC→IDLE and RACC→RREC, each when the state's cycle count runs out.
- RREC→IDLE when its count runs out.

With the defaults (20 ns clock, GRADE=0) the counts are:
- WGAP: 2 cycles.
- WDRV: 2 cycles.
- WREC: 1 cycle.
- RACC: 5 cycles.
- RREC: 2 cycles.

Top module: `sram_ctrl`

## Requirements
- R1: After reset and whenever ready is high, chip enable, write enable, output enable and both byte strobes are high (inactive), and the data drive enable is low.
- R2: For an accepted write, chip enable and write enable are both low for exactly 4 consecutive cycles starting the cycle after acceptance (WGAP plus WDRV at the defaults). Output enable stays high for the whole write.
- R3: During a write, the data drive enable is low for the first 2 cycles of the write-enable-low window. It is high for the last 2 cycles of that window and for exactly one cycle after write enable rises, and then it drops. The drive enable is never high while output enable is low.
- R4: During an access, the lower strobe is low exactly when byte enable bit 0 is set, and the upper strobe is low exactly when bit 1 is set. A write changes only the lanes whose enable is set; with both enables clear, the stored word is left unchanged.
- R5: For an accepted read, chip enable and output enable are low and write enable is high for exactly 5 cycles. The data input is captured on the last of those cycles.
- R6: After a read, the response valid signal pulses high for exactly one cycle, in the cycle after the read window. The response data carries the memory word on enabled lanes and zero on disabled lanes.
- R7: Ready is low from the cycle after acceptance until the sequence and its recovery finish. That is 5 cycles for a write and 7 cycles for a read at the defaults.
- R8: The memory address equals the accepted request's address and does not change while chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| rsp_valid | output | 1 | One-cycle read-data-valid pulse |
| rsp_rdata | output | 16 | Captured read data |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dout | output | 16 | Data toward memory |
| mem_din | input | 16 | Data from memory |
| mem_dout_en | output | 1 | Controller data drive enable |

## Verification
The assertions check the following on every cycle:
- The parked strobe levels while ready is high.
- That the drive enable and output enable are never both asserted.
- That output enable is high while write enable is low.
- That the address holds steady under chip enable.
- That the response pulse lasts a single cycle.

Only the bench's scenarios can show the rest:
- The exact cycle counts of each strobe window.
- The placement of the turnaround gap and the hold cycle.
- Byte-lane merging into stored words.
- The zeroing of disabled read lanes.

The bench shows these by running a memory model and a shadow copy of its contents across directed and random request sequences.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WGAP,
        ST_WDRV,
        ST_WREC,
        ST_RACC,
        ST_RREC
    } sram_state_t;

    // Round a nanosecond interval up to whole clock cycles, minimum one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_step_timer.sv
module sram_step_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_lane_cap.sv
module sram_lane_cap #(
    parameter int LANES = 2,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap,
    input  logic [LANES-1:0]    lane_en,
    input  logic [LANES*LW-1:0] din,
    output logic [LANES*LW-1:0] dq
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                dq[g*LW +: LW] <= '0;
            else if (cap)
                dq[g*LW +: LW] <= lane_en[g] ? din[g*LW +: LW] : '0;
        end
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW     = 18,
    parameter int LANES  = 2,
    parameter int LW     = 8,
    parameter int CLK_NS = 20,
    parameter int GRADE  = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [AW-1:0]       req_addr,
    input  logic [LANES*LW-1:0] req_wdata,
    input  logic [LANES-1:0]    req_be,
    output logic                rsp_valid,
    output logic [LANES*LW-1:0] rsp_rdata,
    output logic [AW-1:0]       mem_addr,
    output logic                mem_ce_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic                mem_lb_n,
    output logic                mem_ub_n,
    output logic [LANES*LW-1:0] mem_dout,
    input  logic [LANES*LW-1:0] mem_din,
    output logic                mem_dout_en
);
    localparam int DW       = LANES * LW;
    localparam int T_CYC    = (GRADE == 0) ? 85 : 100;
    localparam int T_WP     = (GRADE == 0) ? 40 : 50;
    localparam int T_DS     = (GRADE == 0) ? 35 : 40;
    localparam int T_OEACC  = (GRADE == 0) ? 40 : 50;
    localparam int T_REL    = (GRADE == 0) ? 35 : 40;

    localparam int C_GAP    = ns_to_cyc(T_REL, CLK_NS);
    localparam int C_DRV    = imax(ns_to_cyc(T_DS, CLK_NS),
                                   imax(ns_to_cyc(T_WP, CLK_NS) - C_GAP, 1));
    localparam int C_WREC   = imax(1, ns_to_cyc(T_CYC, CLK_NS) - C_GAP - C_DRV);
    localparam int C_RACC   = imax(ns_to_cyc(T_CYC, CLK_NS), ns_to_cyc(T_OEACC, CLK_NS));
    localparam int C_RREC   = ns_to_cyc(T_REL, CLK_NS);
    localparam int C_MAX    = imax(imax(C_GAP, C_DRV), imax(imax(C_WREC, C_RACC), C_RREC));
    localparam int CW       = (C_MAX < 2) ? 1 : $clog2(C_MAX);

    sram_state_t     state, next_state;
    logic            t_load, t_done, accept, capture;
    logic [CW-1:0]   t_val;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   wdata_q;
    logic [LANES-1:0] be_q;
    logic            active;

    assign accept = req_valid && (state == ST_IDLE);

    always_comb begin
        next_state = state;
        t_load     = 1'b0;
        t_val      = '0;
        unique case (state)
            ST_IDLE: if (accept) begin
                next_state = req_write ? ST_WGAP : ST_RACC;
                t_load     = 1'b1;
                t_val      = req_write ? CW'(C_GAP - 1) : CW'(C_RACC - 1);
            end
            ST_WGAP: if (t_done) begin
                next_state = ST_WDRV; t_load = 1'b1; t_val = CW'(C_DRV - 1);
            end
            ST_WDRV: if (t_done) begin
                next_state = ST_WREC; t_load = 1'b1; t_val = CW'(C_WREC - 1);
            end
            ST_WREC: if (t_done) next_state = ST_IDLE;
            ST_RACC: if (t_done) begin
                next_state = ST_RREC; t_load = 1'b1; t_val = CW'(C_RREC - 1);
            end
            ST_RREC: if (t_done) next_state = ST_IDLE;
            default: next_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            addr_q    <= '0;
            wdata_q   <= '0;
            be_q      <= '0;
            rsp_valid <= 1'b0;
        end else begin
            state     <= next_state;
            rsp_valid <= capture;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
        end
    end

    sram_step_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
    );

    assign capture = (state == ST_RACC) && t_done;

    sram_lane_cap #(.LANES(LANES), .LW(LW)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap(capture), .lane_en(be_q),
        .din(mem_din), .dq(rsp_rdata)
    );

    always_comb begin
        req_ready   = 1'b0;
        mem_ce_n    = 1'b1;
        mem_we_n    = 1'b1;
        mem_oe_n    = 1'b1;
        mem_dout_en = 1'b0;
        active      = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_WGAP: begin mem_ce_n = 1'b0; mem_we_n = 1'b0; active = 1'b1; end
            ST_WDRV: begin mem_ce_n = 1'b0; mem_we_n = 1'b0; mem_dout_en = 1'b1; active = 1'b1; end
            ST_WREC: mem_dout_en = 1'b1;
            ST_RACC: begin mem_ce_n = 1'b0; mem_oe_n = 1'b0; active = 1'b1; end
            ST_RREC: ;
            default: ;
        endcase
    end

    assign mem_lb_n = !(active && be_q[0]);
    assign mem_ub_n = !(active && be_q[LANES-1]);
    assign mem_addr = addr_q;
    assign mem_dout = wdata_q;

    // R1
    idle_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dout_en));
    // R3
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dout_en && !mem_oe_n));
    // R2
    oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);
    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R7
    busy_when_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);
endmodule

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata, mem_dout, mem_din;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dout_en;

    int errors = 0, checks = 0, cyc = 0;
    logic [15:0] model [256];
    logic [15:0] shadow [256];

    always #10 clk = ~clk;

    sram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dout(mem_dout),
        .mem_din(mem_din), .mem_dout_en(mem_dout_en)
    );

    // Memory model: floating lanes read back as A5.
    wire rd_on = !mem_ce_n && mem_we_n && !mem_oe_n;
    assign mem_din[7:0]  = (rd_on && !mem_lb_n) ? model[mem_addr[7:0]][7:0]  : 8'hA5;
    assign mem_din[15:8] = (rd_on && !mem_ub_n) ? model[mem_addr[7:0]][15:8] : 8'hA5;

    always @(negedge clk) begin
        if (!mem_ce_n && !mem_we_n && mem_dout_en) begin
            if (!mem_lb_n) model[mem_addr[7:0]][7:0]  <= mem_dout[7:0];
            if (!mem_ub_n) model[mem_addr[7:0]][15:8] <= mem_dout[15:8];
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            finish_run();
        end
    end

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] be);
        return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
    endfunction

    function automatic logic [15:0] rd_exp(input logic [15:0] w, input logic [1:0] be);
        return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    endfunction

    task automatic do_req(input bit wr, input logic [17:0] a, input logic [15:0] d,
                          input logic [1:0] be);
        int busy = 0, welow = 0, cerun = 0, rv_at = -1, rv_cnt = 0;
        bit drv_bad = 0, oe_bad = 0, strobe_bad = 0, addr_bad = 0;
        logic [15:0] got = '0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k < 40; k++) begin
            if (req_ready) break;
            busy++;
            if (!mem_we_n) welow++;
            if (!mem_ce_n) cerun++;
            if (wr) begin
                if (mem_dout_en != (k >= 3 && k <= 5)) drv_bad = 1;
                if (!mem_oe_n) oe_bad = 1;
                if (!mem_we_n != (k <= 4)) drv_bad = 1;
            end else begin
                if (mem_dout_en || !mem_we_n) drv_bad = 1;
                if (!mem_oe_n != (k <= 5)) oe_bad = 1;
            end
            if (!mem_ce_n) begin
                if (mem_lb_n != !be[0] || mem_ub_n != !be[1]) strobe_bad = 1;
                if (mem_addr != a) addr_bad = 1;
            end else if (!mem_lb_n || !mem_ub_n) strobe_bad = 1;
            if (rsp_valid) begin rv_cnt++; rv_at = k; got = rsp_rdata; end
            @(negedge clk);
        end
        chk("R7 busy cycles", busy == (wr ? 5 : 7), busy, wr ? 5 : 7);
        chk("R4 byte strobes", !strobe_bad, strobe_bad, 0);
        chk("R8 address", !addr_bad, addr_bad, 0);
        if (wr) begin
            chk("R2 we low cycles", welow == 4 && cerun == 4, welow, 4);
            chk("R2 oe high in write", !oe_bad, oe_bad, 0);
            chk("R3 drive window", !drv_bad, drv_bad, 0);
            shadow[a[7:0]] = merge(shadow[a[7:0]], d, be);
        end else begin
            chk("R5 read window", cerun == 5 && !oe_bad && !drv_bad, cerun, 5);
            chk("R6 rsp pulse", rv_cnt == 1 && rv_at == 6, rv_at, 6);
            chk("R6 rsp data", got == rd_exp(shadow[a[7:0]], be), got, rd_exp(shadow[a[7:0]], be));
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) begin model[i] = 16'h0000; shadow[i] = 16'h0000; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset strobes", mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n,
            {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'h1f);
        chk("R1 reset drive off", !mem_dout_en, mem_dout_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", req_ready, req_ready, 1);

        do_req(1, 18'h00010, 16'hBEEF, 2'b11);
        do_req(0, 18'h00010, 16'h0000, 2'b11);
        do_req(1, 18'h00010, 16'h1234, 2'b01);   // R4 lower only
        do_req(0, 18'h00010, 16'h0000, 2'b11);
        do_req(1, 18'h00010, 16'h5678, 2'b10);   // R4 upper only
        do_req(0, 18'h00010, 16'h0000, 2'b11);
        do_req(1, 18'h00010, 16'hFFFF, 2'b00);   // R4 no lanes: unchanged
        do_req(0, 18'h00010, 16'h0000, 2'b11);
        do_req(0, 18'h00010, 16'h0000, 2'b01);   // R6 disabled upper lane reads zero
        do_req(0, 18'h00010, 16'h0000, 2'b10);
        do_req(1, 18'h3FFFF, 16'hA55A, 2'b11);   // top address
        do_req(0, 18'h3FFFF, 16'h0000, 2'b11);
        @(negedge clk);
        chk("R1 parked between requests", mem_ce_n && !mem_dout_en && req_ready, req_ready, 1);

        for (int n = 0; n < 80; n++) begin
            logic [17:0] ra;
            ra = {$urandom_range(3, 0) == 0 ? 10'h3FF : 10'h000, 8'($urandom_range(15, 0))};
            do_req(1'($urandom_range(1, 0)), ra, 16'($urandom), 2'($urandom_range(3, 0)));
        end
        finish_run();
    end
endmodule